// File: doc/BRIEF.md
# Carrier Tracking Proportional-Integral Loop Filter

This block is the loop filter of a second-order carrier-recovery loop. Signed phase-error samples arrive with a valid strobe. They are summed in a pre-accumulator until a programmable number of samples has been collected. The batch sum then feeds two paths. The proportional (lead) path scales the batch. The integrating (lag) path adds the scaled batch, plus an optional frequency-error term and an optional sweep term, into a 40-bit accumulator. That accumulator is held between a programmable upper limit and a programmable lower limit.

Each batch starts one filter update. The update emits a 32-bit control word for a numerically controlled oscillator, together with a one-cycle valid pulse. Static configuration inputs control the batch size, the gains, the path enables, the two inversions, the limits and the output routing. These inputs are expected to stay constant while a batch is in flight.

A three-state machine sequences each update:
- IDLE waits for a closed batch. The transition IDLE→UPDATE is taken when a batch closes, and it captures the batch.
- UPDATE registers the lead term and steps the lag accumulator. UPDATE→EMIT is always taken.
- EMIT forms and registers the output word and raises the valid pulse. EMIT→IDLE is always taken.

Sample collection continues during an update, because a closed batch is held in its own register.

Top module: `carrier_pi_filter`

## Requirements
- R1: The 5-bit `cfg_count_m1` field holds the batch size minus one. Exactly `cfg_count_m1`+1 valid samples, from 1 to 32, are summed per filter update. For example, a field value of 3 sums 4 samples.
- R2: The design never loses a sample when samples arrive on consecutive clocks. Each batch produces exactly one single-cycle `nco_valid` pulse. The pulse rises on the third rising edge after the edge that samples the batch's last error. Batches must close at least 3 clocks apart.
- R3: When `cfg_lead_off` is 1, the phase error feeding the lead path is zero.
- R4: When `cfg_lag_off` is 1, the phase error feeding the lag path is zero. The integrator then changes only through the frequency and sweep terms.
- R5: The frequency error and the sweep input are each added into the lag accumulator at a weight of 2^8 accumulator LSBs, that is, 1 LSB of the upper 32 bits. `cfg_freq_off` forces the frequency term to zero. `cfg_sweep_off` forces the sweep term to zero.
- R6: `cfg_inv_phase` negates the batch phase error before both paths. `cfg_inv_freq` negates the frequency error.
- R7: The lag accumulator is 40 bits wide. If the upper 32 bits of the new sum would exceed `lim_hi`, those 32 bits are loaded with `lim_hi` and the low 8 bits are cleared. If they would fall below `lim_lo`, the same happens with `lim_lo`.
- R8: When `cfg_route_lead` is 0, `nco_word` is the upper 32 bits of lead plus lag. When it is 1, `nco_word` is the upper 32 bits of the lead term alone.
- R9: Each path term equals (phase × signed 8-bit gain × 2^10), shifted arithmetically right by the path's 5-bit shift value.
- R10: The lead-plus-lag upper word saturates to 0x7FFFFFFF or 0x80000000 instead of wrapping.
- R11: Synchronous active-high `rst` clears the pre-accumulator, the lag accumulator, `nco_word` and `nco_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_valid | input | 1 | Phase-error sample strobe |
| err_in | input | 16 | Signed phase-error sample |
| freq_err | input | 16 | Signed frequency-error term for the lag path |
| sweep_in | input | 16 | Signed sweep term for the lag path |
| cfg_count_m1 | input | 5 | Samples per batch minus one |
| cfg_lead_off | input | 1 | Zero the phase error into the lead path |
| cfg_lag_off | input | 1 | Zero the phase error into the lag path |
| cfg_freq_off | input | 1 | Zero the frequency term |
| cfg_sweep_off | input | 1 | Zero the sweep term |
| cfg_inv_phase | input | 1 | Negate the phase error |
| cfg_inv_freq | input | 1 | Negate the frequency error |
| cfg_route_lead | input | 1 | 1: output the lead term only; 0: output lead plus lag |
| lead_gain | input | 8 | Signed lead gain mantissa |
| lead_shift | input | 5 | Lead arithmetic right shift |
| lag_gain | input | 8 | Signed lag gain mantissa |
| lag_shift | input | 5 | Lag arithmetic right shift |
| lim_hi | input | 32 | Signed upper limit for the lag accumulator's upper word |
| lim_lo | input | 32 | Signed lower limit for the lag accumulator's upper word |
| nco_valid | output | 1 | One-cycle strobe for a new control word |
| nco_word | output | 32 | Control word for the NCO |

## Verification
Assertions check four properties on every cycle:
- a closed batch always follows a sampled error;
- a closed batch never meets the state machine outside IDLE;
- the output strobe lasts one cycle;
- the lag upper word stays within the limits after each update, and lead-only routing with the lead path zeroed yields a zero word.

The arithmetic can only be shown through the bench's scenarios, which compare every emitted word with an independent model. These scenarios cover the batch sizes, gain and shift scaling, inversion of each error, the frequency and sweep injection with their zero bits, limit clamping on both sides, output saturation, and the clearing of state by reset.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UPDATE = 2'd1,
        ST_EMIT   = 2'd2
    } cpf_state_e;
endpackage

// File: rtl/cpf_preacc.sv
module cpf_preacc #(
    parameter int ERR_W = 16,
    parameter int CNT_W = 5,
    parameter int SUM_W = 22
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    err_valid,
    input  logic signed [ERR_W-1:0] err_in,
    input  logic [CNT_W-1:0]        count_m1,
    output logic                    batch_rdy,
    output logic signed [SUM_W-1:0] batch_sum
);
    localparam int EXT_W = SUM_W - ERR_W;

    logic [CNT_W-1:0]        cnt_q;
    logic signed [SUM_W-1:0] run_q;
    logic signed [SUM_W-1:0] err_ext;
    logic signed [SUM_W-1:0] run_next;

    assign err_ext  = {{EXT_W{err_in[ERR_W-1]}}, err_in};
    assign run_next = run_q + err_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            run_q     <= '0;
            batch_sum <= '0;
            batch_rdy <= 1'b0;
        end else begin
            batch_rdy <= 1'b0;
            if (err_valid) begin
                if (cnt_q >= count_m1) begin
                    batch_sum <= run_next;
                    batch_rdy <= 1'b1;
                    run_q     <= '0;
                    cnt_q     <= '0;
                end else begin
                    run_q <= run_next;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R1: a batch can only close on a sampled error
    assert_batch_after_sample_R1: assert property (@(posedge clk) disable iff (rst)
        batch_rdy |-> $past(err_valid));
endmodule

// File: rtl/cpf_scale.sv
module cpf_scale #(
    parameter int IN_W   = 22,
    parameter int GAIN_W = 8,
    parameter int SH_W   = 5,
    parameter int ACC_W  = 40
) (
    input  logic signed [IN_W-1:0]   x,
    input  logic signed [GAIN_W-1:0] g,
    input  logic [SH_W-1:0]          sh,
    output logic signed [ACC_W-1:0]  y
);
    localparam int PROD_W = IN_W + GAIN_W;
    localparam int ALIGN  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  aligned;

    assign prod    = x * g;
    assign aligned = {prod, {ALIGN{1'b0}}};
    assign y       = aligned >>> sh;
endmodule

// File: rtl/cpf_lag.sv
module cpf_lag #(
    parameter int ACC_W = 40,
    parameter int OUT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd,
    input  logic signed [ACC_W-1:0] incr_a,
    input  logic signed [ACC_W-1:0] incr_b,
    input  logic [OUT_W-1:0]        lim_hi,
    input  logic [OUT_W-1:0]        lim_lo,
    output logic signed [ACC_W-1:0] acc
);
    localparam int FRAC_W = ACC_W - OUT_W;
    localparam int SUM_W  = ACC_W + 2;
    localparam int UP_W   = SUM_W - FRAC_W;

    logic signed [SUM_W-1:0] sum;
    logic signed [UP_W-1:0]  upper;
    logic signed [UP_W-1:0]  hi_ext;
    logic signed [UP_W-1:0]  lo_ext;

    assign sum    = {{2{acc[ACC_W-1]}}, acc} + {{2{incr_a[ACC_W-1]}}, incr_a}
                  + {{2{incr_b[ACC_W-1]}}, incr_b};
    assign upper  = sum[SUM_W-1:FRAC_W];
    assign hi_ext = {{2{lim_hi[OUT_W-1]}}, lim_hi};
    assign lo_ext = {{2{lim_lo[OUT_W-1]}}, lim_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (upd) begin
            if (upper > hi_ext) begin
                acc <= {lim_hi, {FRAC_W{1'b0}}};
            end else if (upper < lo_ext) begin
                acc <= {lim_lo, {FRAC_W{1'b0}}};
            end else begin
                acc <= sum[ACC_W-1:0];
            end
        end
    end

    // R7: after an update the upper word lies within ordered limits
    assert_lag_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        (upd && ($signed(lim_lo) <= $signed(lim_hi))) |=>
        (($signed(acc[ACC_W-1:FRAC_W]) <= $signed($past(lim_hi))) &&
         ($signed(acc[ACC_W-1:FRAC_W]) >= $signed($past(lim_lo)))));
endmodule

// File: rtl/carrier_pi_filter.sv
module carrier_pi_filter #(
    parameter int ERR_W  = 16,
    parameter int CNT_W  = 5,
    parameter int GAIN_W = 8,
    parameter int SH_W   = 5,
    parameter int ACC_W  = 40,
    parameter int OUT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err_valid,
    input  logic [ERR_W-1:0]  err_in,
    input  logic [ERR_W-1:0]  freq_err,
    input  logic [ERR_W-1:0]  sweep_in,
    input  logic [CNT_W-1:0]  cfg_count_m1,
    input  logic              cfg_lead_off,
    input  logic              cfg_lag_off,
    input  logic              cfg_freq_off,
    input  logic              cfg_sweep_off,
    input  logic              cfg_inv_phase,
    input  logic              cfg_inv_freq,
    input  logic              cfg_route_lead,
    input  logic [GAIN_W-1:0] lead_gain,
    input  logic [SH_W-1:0]   lead_shift,
    input  logic [GAIN_W-1:0] lag_gain,
    input  logic [SH_W-1:0]   lag_shift,
    input  logic [OUT_W-1:0]  lim_hi,
    input  logic [OUT_W-1:0]  lim_lo,
    output logic              nco_valid,
    output logic [OUT_W-1:0]  nco_word
);
    import cpf_pkg::*;

    localparam int PH_W   = ERR_W + CNT_W + 1;
    localparam int FRAC_W = ACC_W - OUT_W;
    localparam int PAD_W  = ACC_W - ERR_W - FRAC_W;

    cpf_state_e state_q, state_d;

    logic                    batch_rdy;
    logic signed [PH_W-1:0]  batch_sum;
    logic signed [PH_W-1:0]  ph_q;
    logic signed [PH_W-1:0]  lead_in, lag_in;
    logic signed [ACC_W-1:0] lead_term, lag_term, lead_q, lag_acc;
    logic signed [ACC_W-1:0] freq_ext, sweep_ext, freq_term, sweep_term, inject;
    logic signed [ACC_W:0]   total;
    logic [OUT_W:0]          top_part;
    logic [OUT_W-1:0]        word_sat;

    cpf_preacc #(.ERR_W(ERR_W), .CNT_W(CNT_W), .SUM_W(PH_W)) u_preacc (
        .clk       (clk),
        .rst       (rst),
        .err_valid (err_valid),
        .err_in    (err_in),
        .count_m1  (cfg_count_m1),
        .batch_rdy (batch_rdy),
        .batch_sum (batch_sum)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = batch_rdy ? ST_UPDATE : ST_IDLE;
            ST_UPDATE: state_d = ST_EMIT;
            ST_EMIT:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign lead_in = cfg_lead_off ? '0 : ph_q;
    assign lag_in  = cfg_lag_off  ? '0 : ph_q;

    cpf_scale #(.IN_W(PH_W), .GAIN_W(GAIN_W), .SH_W(SH_W), .ACC_W(ACC_W)) u_lead_scale (
        .x (lead_in), .g (lead_gain), .sh (lead_shift), .y (lead_term)
    );

    cpf_scale #(.IN_W(PH_W), .GAIN_W(GAIN_W), .SH_W(SH_W), .ACC_W(ACC_W)) u_lag_scale (
        .x (lag_in), .g (lag_gain), .sh (lag_shift), .y (lag_term)
    );

    assign freq_ext   = {{PAD_W{freq_err[ERR_W-1]}}, freq_err, {FRAC_W{1'b0}}};
    assign sweep_ext  = {{PAD_W{sweep_in[ERR_W-1]}}, sweep_in, {FRAC_W{1'b0}}};
    assign freq_term  = cfg_freq_off  ? '0 : (cfg_inv_freq ? -freq_ext : freq_ext);
    assign sweep_term = cfg_sweep_off ? '0 : sweep_ext;
    assign inject     = freq_term + sweep_term;

    cpf_lag #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_lag (
        .clk    (clk),
        .rst    (rst),
        .upd    (state_q == ST_UPDATE),
        .incr_a (lag_term),
        .incr_b (inject),
        .lim_hi (lim_hi),
        .lim_lo (lim_lo),
        .acc    (lag_acc)
    );

    assign total    = {lead_q[ACC_W-1], lead_q}
                    + (cfg_route_lead ? '0 : {lag_acc[ACC_W-1], lag_acc});
    assign top_part = total[ACC_W:FRAC_W];
    assign word_sat = (top_part[OUT_W] != top_part[OUT_W-1])
                    ? {top_part[OUT_W], {(OUT_W-1){~top_part[OUT_W]}}}
                    : top_part[OUT_W-1:0];

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= '0;
            lead_q    <= '0;
            nco_word  <= '0;
            nco_valid <= 1'b0;
        end else begin
            nco_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (batch_rdy) ph_q <= cfg_inv_phase ? -batch_sum : batch_sum;
                end
                ST_UPDATE: lead_q <= lead_term;
                ST_EMIT: begin
                    nco_word  <= word_sat;
                    nco_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R2: a closed batch must find the machine idle
    assert_no_batch_drop_R2: assert property (@(posedge clk) disable iff (rst)
        batch_rdy |-> (state_q == ST_IDLE));

    // R2: one strobe per update
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        nco_valid |=> !nco_valid);

    // R3 and R8: lead-only routing with lead zeroed gives a zero word
    assert_lead_zero_route_R8: assert property (@(posedge clk) disable iff (rst)
        (nco_valid && $past(cfg_route_lead) && $past(cfg_lead_off, 2)) |-> (nco_word == '0));
endmodule

// File: tb/carrier_pi_filter_bench.sv
module carrier_pi_filter_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        err_valid = 1'b0;
    logic [15:0] err_d = '0;
    int          freq = 0, sweep = 0;
    int          count_m1 = 0;
    logic        lead_off = 0, lag_off = 0, freq_off = 1, sweep_off = 1;
    logic        inv_phase = 0, inv_freq = 0, route_lead = 0;
    int          lead_gain = 1, lead_shift = 0, lag_gain = 0, lag_shift = 0;
    int          lim_hi = 32'h7FFFFFFF, lim_lo = 32'h80000000;

    logic        nco_valid;
    logic [31:0] nco_word;

    carrier_pi_filter u_carrier_pi_filter (
        .clk(clk), .rst(rst), .err_valid(err_valid), .err_in(err_d),
        .freq_err(freq[15:0]), .sweep_in(sweep[15:0]), .cfg_count_m1(count_m1[4:0]),
        .cfg_lead_off(lead_off), .cfg_lag_off(lag_off), .cfg_freq_off(freq_off),
        .cfg_sweep_off(sweep_off), .cfg_inv_phase(inv_phase), .cfg_inv_freq(inv_freq),
        .cfg_route_lead(route_lead), .lead_gain(lead_gain[7:0]), .lead_shift(lead_shift[4:0]),
        .lag_gain(lag_gain[7:0]), .lag_shift(lag_shift[4:0]), .lim_hi(lim_hi),
        .lim_lo(lim_lo), .nco_valid(nco_valid), .nco_word(nco_word)
    );

    int          total_checks = 0;
    int          bad_checks = 0;
    longint      model_lag = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_step(input longint sum);
        longint phs, li, gi, lead, lagt, f, s, inc, nxt, up, tot, tw;
        phs  = inv_phase ? -sum : sum;
        li   = lead_off ? 0 : phs;
        gi   = lag_off  ? 0 : phs;
        lead = (li * longint'(lead_gain) * 1024) >>> lead_shift;
        lagt = (gi * longint'(lag_gain)  * 1024) >>> lag_shift;
        f    = freq_off  ? 0 : (inv_freq ? -longint'(freq) : longint'(freq));
        s    = sweep_off ? 0 : longint'(sweep);
        inc  = lagt + f * 256 + s * 256;
        nxt  = model_lag + inc;
        up   = nxt >>> 8;
        if (up > longint'(lim_hi))      model_lag = longint'(lim_hi) * 256;
        else if (up < longint'(lim_lo)) model_lag = longint'(lim_lo) * 256;
        else                            model_lag = nxt;
        tot = lead + (route_lead ? 0 : model_lag);
        tw  = tot >>> 8;
        if (tw > 64'sd2147483647)       tw = 64'sd2147483647;
        else if (tw < -64'sd2147483648) tw = -64'sd2147483648;
        return tw[31:0];
    endfunction

    // drive one batch of count_m1+1 samples: base, base+step, ...
    task automatic run_batch(input int base, input int step, input string tag);
        longint sum = 0;
        for (int i = 0; i <= count_m1; i++) begin
            @(negedge clk);
            err_valid = 1'b1;
            err_d     = 16'(base + i * step);
            sum      += longint'($signed(err_d));
        end
        exp_q.push_back(model_step(sum));
        tag_q.push_back(tag);
        @(negedge clk);
        err_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && nco_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected strobe", nco_word, 0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(nco_word == e, t, nco_word, e);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(nco_word == 0, "R11 reset word", nco_word, 0);
        check(nco_valid == 0, "R11 reset strobe", nco_valid, 0);
        rst = 1'b0;
        @(negedge clk);

        // R9 R8 R1: four-sample batch, lead only
        count_m1 = 3; lead_gain = 3; lead_shift = 4; route_lead = 1;
        run_batch(100, 100, "R1 R9 four-sample lead");
        lead_gain = -5; lead_shift = 0;
        run_batch(-7, 3, "R9 negative gain");

        // R2 R4: single-sample batches integrate
        count_m1 = 0; route_lead = 0; lead_gain = 1; lead_shift = 2;
        lag_gain = 2; lag_shift = 1;
        run_batch(1000, 0, "R2 single-sample integrate 1");
        run_batch(-300, 0, "R2 single-sample integrate 2");

        // R1: 32-sample batch on consecutive clocks
        count_m1 = 31;
        run_batch(-50, 7, "R1 thirty-two samples");

        // R3: lead path zeroed with lead-only routing
        count_m1 = 1; lead_off = 1; route_lead = 1;
        run_batch(2000, 1, "R3 lead zeroed");
        route_lead = 0;
        run_batch(2000, 1, "R3 lead zeroed lag visible");
        lead_off = 0;

        // R4: lag input zeroed holds integrator
        lag_off = 1;
        run_batch(5000, 0, "R4 lag zeroed 1");
        run_batch(-5000, 0, "R4 lag zeroed 2");
        lag_off = 0;

        // R5: frequency and sweep injection
        freq_off = 0; freq = 1234; lag_off = 1;
        run_batch(10, 0, "R5 frequency injected");
        sweep_off = 0; sweep = -77;
        run_batch(10, 0, "R5 sweep plus frequency");
        freq_off = 1;
        run_batch(10, 0, "R5 frequency zeroed");
        sweep_off = 1; lag_off = 0;

        // R6: inversions
        inv_phase = 1;
        run_batch(400, 10, "R6 phase inverted");
        inv_phase = 0; freq_off = 0; inv_freq = 1; freq = 900;
        run_batch(0, 0, "R6 frequency inverted");
        inv_freq = 0; freq_off = 1;

        // R7: clamp at both limits
        lead_off = 1; lim_hi = 100; lim_lo = -50; lag_gain = 100; lag_shift = 0;
        run_batch(30000, 0, "R7 upper clamp");
        run_batch(30000, 0, "R7 upper clamp held");
        run_batch(-30000, 0, "R7 lower clamp");
        lead_off = 0;

        // R10: saturation of lead plus lag
        lim_hi = 32'h7FFFFFFF; lim_lo = 32'h80000000;
        count_m1 = 31; lead_gain = 127; lead_shift = 0; lag_gain = 127; lag_shift = 0;
        for (int k = 0; k < 6; k++) run_batch(32000, 0, "R10 positive saturation");
        for (int k = 0; k < 10; k++) run_batch(-32000, 0, "R10 negative saturation");

        // R11: reset mid-stream clears the integrator
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(nco_word == 0, "R11 word after reset", nco_word, 0);
        check(nco_valid == 0, "R11 strobe after reset", nco_valid, 0);
        rst = 1'b0; model_lag = 0;
        count_m1 = 2; lead_gain = 1; lead_shift = 3; lag_gain = 1; lag_shift = 3;
        run_batch(64, 0, "R11 integrator restarted");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2 pending results", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end
endmodule